// File: doc/BRIEF.md
# Hybrid Capacitor/Ladder SAR Conversion Sequencer

This block is the digital sequencer for a four-lane successive-approximation converter. Each lane has a small array of unit capacitors. The upper bits of a conversion are found by moving a thermometer count of reference-connected capacitors up or down. The low seven bits come from a binary search on the tap of a resistor ladder, which all lanes share and which drives the bottom plate of a dummy capacitor. In the narrow mode, all four lanes sample together and are then resolved one after another, lane 0 first, at 10 bits each. In the wide mode, the four arrays act as one 32-unit array, and a single 12-bit result is resolved on lane 0.

A start pulse launches a conversion. The sequencer then drives the shared sample switch, the bottom-plate controls of every unit, the ladder tap and its enable, and one active-low comparator enable per lane. It reads back one comparator bit per lane and stores each finished code in a per-lane result slot. During the first two ladder decisions it also drives a brief low-impedance assist path, which is kept off during the half cycle before each decision is latched.

Top module: `hybrid_sar_seq`

## Requirements
- R1: After an accepted start, `sample_sw` is high for exactly 2 cycles (narrow mode) or 3 cycles (wide mode). During those cycles every `cap_top` bit is 0 and every `cmp_en_n` bit is 1.
- R2: In narrow mode, lanes 0, 1, 2 and 3 are resolved in that order, each for 12 cycles. In wide mode a single 14-cycle pass runs on lane 0. Throughout a pass, exactly the active lane's `cmp_en_n` bit is 0.
- R3: `cap_top` bit 8g+k drives unit k of lane g. In narrow mode, units 0..6 of the active lane form a thermometer (units 0..n-1 on the reference), unit 7 is the dummy and stays 0, and the other lanes read 0. In wide mode, bits 0..30 form one thermometer and bit 31 is the dummy. The capacitor search is a binary search: the first trial is 4 units (narrow) or 16 units (wide), and a comparator 1 keeps the trial bit.
- R4: After the last capacitor decision there is one hand-over cycle in which the thermometer count equals the resolved upper code. If the last capacitor bit is 0, this returns one unit to ground. The count is then held through the ladder cycles and the store cycle.
- R5: Next come 7 ladder cycles with `ladder_en` high. In each, `ladder_tap` equals the 7-bit trial code minus one, so the first tap is 63, and a 0 result moves the next tap to 31. Outside these cycles `ladder_en` and `ladder_tap` are 0.
- R6: In the first two ladder cycles only, `assist_m` and the single `assist_z` bit indexed by the trial code's top two bits are high while the clock is high. At all other times, including every clock-low half, they are 0.
- R7: After the store cycle, slot g (`result` bits 12g+11..12g) holds the code (upper bits × 128 + ladder bits), zero-extended. In wide mode only slot 0 is written and the other slots are unchanged.
- R8: `done` is high for exactly one cycle, the first cycle in which all of that conversion's results are visible.
- R9: A start pulse, and any change of the mode input, during a conversion has no effect. No new sampling window follows `done`.
- R10: The comparator inputs of disabled lanes have no effect on any result.
- R11: After reset, `sample_sw`, `cap_top`, `ladder_en`, `ladder_tap`, the assist outputs, `done` and `result` are 0, and `cmp_en_n` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode12 | input | 1 | 1 = single 12-bit lane, 0 = four 10-bit lanes; captured with start |
| start | input | 1 | Conversion request, accepted only when idle |
| cmp_out | input | 4 | Comparator result per lane (1 = input at or above trial) |
| sample_sw | output | 1 | Sample switches closed |
| cap_top | output | 32 | Unit bottom-plate control, 1 = reference, 0 = ground |
| ladder_en | output | 1 | Ladder drives the dummy capacitor |
| ladder_tap | output | 7 | Selected ladder tap |
| cmp_en_n | output | 4 | Active-low comparator enable per lane |
| assist_m | output | 1 | Common assist switch |
| assist_z | output | 4 | Assist level switches |
| result | output | 48 | Four 12-bit result slots |
| done | output | 1 | One-cycle completion flag |

## Verification
The bench builds the block with its default parameters: four lanes of eight units, a 7-bit ladder, and 3 or 5 capacitor-resolved bits. With these values both modes, the full four-lane order and the merged 31-unit thermometer are all reachable. A comparator model in the bench derives each decision from the driven thermometer and tap, so the extreme codes 0 and full scale reach the lowest and highest taps. Random codes, together with noise on disabled lanes, exercise every search path.

// File: rtl/hsar_pkg.sv
package hsar_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SAMP, ST_CONV} seq_st_t;
  typedef enum logic [1:0] {PH_MSB, PH_HAND, PH_LAD, PH_STORE} ph_t;
endpackage

// File: rtl/hsar_timer.sv
module hsar_timer
  import hsar_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int MSB10 = 3,
  parameter int MSB12 = 5,
  parameter int LADB  = 7,
  parameter int SMP10 = 2,
  parameter int SMP12 = 3,
  localparam int CHW   = $clog2(NCH),
  localparam int STEPW = $clog2(MSB12 + LADB + 2),
  localparam int POSW  = $clog2((MSB12 > LADB) ? MSB12 : LADB),
  localparam int SMPW  = $clog2(SMP12)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode_in,
  output seq_st_t          st,
  output logic             mode_q,
  output logic [CHW-1:0]   ch,
  output ph_t              phase,
  output logic [POSW-1:0]  msb_pos,
  output logic [POSW-1:0]  lad_pos,
  output logic             done
);
  logic [STEPW-1:0] step, nmsb, last_step;
  logic [SMPW-1:0]  scnt, smp_last;

  assign nmsb      = mode_q ? STEPW'(MSB12) : STEPW'(MSB10);
  assign last_step = nmsb + STEPW'(LADB + 1);
  assign smp_last  = mode_q ? SMPW'(SMP12 - 1) : SMPW'(SMP10 - 1);
  assign msb_pos   = POSW'(nmsb - step - 1'b1);
  assign lad_pos   = POSW'(nmsb + STEPW'(LADB) - step);

  always_comb begin
    if (step < nmsb)                      phase = PH_MSB;
    else if (step == nmsb)                phase = PH_HAND;
    else if (step <= nmsb + STEPW'(LADB)) phase = PH_LAD;
    else                                  phase = PH_STORE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      mode_q <= 1'b0;
      ch     <= '0;
      step   <= '0;
      scnt   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st     <= ST_SAMP;
          mode_q <= mode_in;
          scnt   <= '0;
        end
        ST_SAMP: if (scnt == smp_last) begin
          st   <= ST_CONV;
          ch   <= '0;
          step <= '0;
        end else begin
          scnt <= scnt + 1'b1;
        end
        ST_CONV: if (step == last_step) begin
          step <= '0;
          if (mode_q || ch == CHW'(NCH - 1)) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            ch <= ch + 1'b1;
          end
        end else begin
          step <= step + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1: the sampling window lasts 2 or 3 cycles depending on the captured mode
  p_samp_len_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(st == ST_CONV) |-> ($past(st == ST_SAMP, 2) && ($past(st == ST_SAMP, 3) == mode_q)));
  // R9: mode cannot change once a conversion is under way
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> $stable(mode_q));
  // R8: completion flag is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R2: the wide mode never leaves lane 0
  p_wide_lane_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CONV && mode_q) |-> (ch == '0));
endmodule

// File: rtl/hsar_sar.sv
module hsar_sar
  import hsar_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int MSB10 = 3,
  parameter int MSB12 = 5,
  parameter int LADB  = 7,
  localparam int CHW  = $clog2(NCH),
  localparam int POSW = $clog2((MSB12 > LADB) ? MSB12 : LADB),
  localparam int RESW = MSB12 + LADB
) (
  input  logic                clk,
  input  logic                rst,
  input  seq_st_t             st,
  input  ph_t                 phase,
  input  logic                mode_q,
  input  logic [CHW-1:0]      ch,
  input  logic [POSW-1:0]     msb_pos,
  input  logic [POSW-1:0]     lad_pos,
  input  logic [NCH-1:0]      cmp_out,
  output logic [MSB12-1:0]    msb_trial,
  output logic [LADB-1:0]     lad_trial,
  output logic [NCH*RESW-1:0] result
);
  logic [MSB12-1:0] msb_acc;
  logic [LADB-1:0]  lsb_acc;
  logic [RESW-1:0]  res_q [NCH];
  logic [CHW-1:0]   sel;
  logic             conv, bit_now;

  assign conv    = (st == ST_CONV);
  assign sel     = mode_q ? '0 : ch;
  assign bit_now = cmp_out[sel];

  assign msb_trial = msb_acc | ((conv && phase == PH_MSB) ? (MSB12'(1) << msb_pos) : '0);
  assign lad_trial = lsb_acc | ((conv && phase == PH_LAD) ? (LADB'(1) << lad_pos) : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      msb_acc <= '0;
      lsb_acc <= '0;
      for (int i = 0; i < NCH; i++) res_q[i] <= '0;
    end else if (!conv) begin
      msb_acc <= '0;
      lsb_acc <= '0;
    end else begin
      case (phase)
        PH_MSB: msb_acc[msb_pos] <= bit_now;
        PH_LAD: lsb_acc[lad_pos] <= bit_now;
        PH_STORE: begin
          res_q[sel] <= {msb_acc, lsb_acc};
          msb_acc    <= '0;
          lsb_acc    <= '0;
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    assign result[g*RESW +: RESW] = res_q[g];
  end

  // R3: the first capacitor trial of each pass puts half the array on the reference
  p_msb_mid_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(conv) |-> (msb_trial == (mode_q ? (MSB12'(1) << (MSB12 - 1)) : (MSB12'(1) << (MSB10 - 1)))));
endmodule

// File: rtl/hsar_drive.sv
module hsar_drive
  import hsar_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int UNITS = 8,
  parameter int MSB12 = 5,
  parameter int LADB  = 7,
  localparam int CHW  = $clog2(NCH),
  localparam int POSW = $clog2((MSB12 > LADB) ? MSB12 : LADB),
  localparam int CAPW = NCH * UNITS
) (
  input  logic             clk,
  input  logic             rst,
  input  seq_st_t          st,
  input  ph_t              phase,
  input  logic             mode_q,
  input  logic [CHW-1:0]   ch,
  input  logic [MSB12-1:0] msb_trial,
  input  logic [LADB-1:0]  lad_trial,
  input  logic [POSW-1:0]  lad_pos,
  output logic             sample_sw,
  output logic [CAPW-1:0]  cap_top,
  output logic             ladder_en,
  output logic [LADB-1:0]  ladder_tap,
  output logic [NCH-1:0]   cmp_en_n,
  output logic             assist_m,
  output logic [3:0]       assist_z
);
  logic conv, zwin;

  assign conv       = (st == ST_CONV);
  assign sample_sw  = (st == ST_SAMP);
  assign ladder_en  = conv && (phase == PH_LAD);
  assign ladder_tap = ladder_en ? (lad_trial - LADB'(1)) : '0;
  assign zwin       = ladder_en && (lad_pos >= POSW'(LADB - 2));
  assign assist_m   = zwin & clk;

  for (genvar z = 0; z < 4; z++) begin : g_assist
    assign assist_z[z] = zwin & clk & (lad_trial[LADB-1 -: 2] == 2'(z));
  end

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    assign cmp_en_n[g] = !(conv && (mode_q ? (g == 0) : (ch == CHW'(g))));
    for (genvar k = 0; k < UNITS; k++) begin : g_unit
      localparam int IDX = g * UNITS + k;
      logic on_wide, on_narrow;
      assign on_wide   = (IDX < CAPW - 1) && (msb_trial > MSB12'(IDX));
      assign on_narrow = (k < UNITS - 1) && (ch == CHW'(g)) && (msb_trial > MSB12'(k));
      assign cap_top[IDX] = conv && (mode_q ? on_wide : on_narrow);
    end
  end

  // R2: at most one comparator is enabled at any time
  p_one_cmp_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cmp_en_n));
  // R5: the ladder search always opens at the midpoint tap
  p_tap_first_r5: assert property (@(posedge clk) disable iff (rst)
    (ladder_en && !$past(ladder_en)) |-> (ladder_tap == LADB'((1 << (LADB - 1)) - 1)));
  // R4: the capacitor array is frozen while the ladder searches
  p_cap_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ladder_en && $past(ladder_en)) |-> $stable(cap_top));
  // R1: nothing is on the reference while sampling
  p_samp_clear_r1: assert property (@(posedge clk) disable iff (rst)
    sample_sw |-> (cap_top == '0 && (&cmp_en_n)));
endmodule

// File: rtl/hybrid_sar_seq.sv
module hybrid_sar_seq
  import hsar_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int UNITS = 8,
  parameter int MSB10 = 3,
  parameter int MSB12 = 5,
  parameter int LADB  = 7,
  parameter int SMP10 = 2,
  parameter int SMP12 = 3,
  localparam int CHW  = $clog2(NCH),
  localparam int POSW = $clog2((MSB12 > LADB) ? MSB12 : LADB),
  localparam int CAPW = NCH * UNITS,
  localparam int RESW = MSB12 + LADB
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode12,
  input  logic                start,
  input  logic [NCH-1:0]      cmp_out,
  output logic                sample_sw,
  output logic [CAPW-1:0]     cap_top,
  output logic                ladder_en,
  output logic [LADB-1:0]     ladder_tap,
  output logic [NCH-1:0]      cmp_en_n,
  output logic                assist_m,
  output logic [3:0]          assist_z,
  output logic [NCH*RESW-1:0] result,
  output logic                done
);
  seq_st_t          st;
  ph_t              phase;
  logic             mode_q;
  logic [CHW-1:0]   ch;
  logic [POSW-1:0]  msb_pos, lad_pos;
  logic [MSB12-1:0] msb_trial;
  logic [LADB-1:0]  lad_trial;

  hsar_timer #(
    .NCH(NCH), .MSB10(MSB10), .MSB12(MSB12), .LADB(LADB), .SMP10(SMP10), .SMP12(SMP12)
  ) u_timer (
    .clk(clk), .rst(rst), .start(start), .mode_in(mode12),
    .st(st), .mode_q(mode_q), .ch(ch), .phase(phase),
    .msb_pos(msb_pos), .lad_pos(lad_pos), .done(done)
  );

  hsar_sar #(
    .NCH(NCH), .MSB10(MSB10), .MSB12(MSB12), .LADB(LADB)
  ) u_sar (
    .clk(clk), .rst(rst), .st(st), .phase(phase), .mode_q(mode_q), .ch(ch),
    .msb_pos(msb_pos), .lad_pos(lad_pos), .cmp_out(cmp_out),
    .msb_trial(msb_trial), .lad_trial(lad_trial), .result(result)
  );

  hsar_drive #(
    .NCH(NCH), .UNITS(UNITS), .MSB12(MSB12), .LADB(LADB)
  ) u_drive (
    .clk(clk), .rst(rst), .st(st), .phase(phase), .mode_q(mode_q), .ch(ch),
    .msb_trial(msb_trial), .lad_trial(lad_trial), .lad_pos(lad_pos),
    .sample_sw(sample_sw), .cap_top(cap_top), .ladder_en(ladder_en),
    .ladder_tap(ladder_tap), .cmp_en_n(cmp_en_n), .assist_m(assist_m),
    .assist_z(assist_z)
  );
endmodule

// File: tb/hybrid_sar_seq_tb.sv
module hybrid_sar_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode12 = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  cmp;
  logic        sample_sw, ladder_en, assist_m, done;
  logic [31:0] cap_top;
  logic [6:0]  ladder_tap;
  logic [3:0]  cmp_en_n, assist_z;
  logic [47:0] result;

  int   nchk = 0, nerr = 0, cyc = 0;
  bit   finished = 1'b0;
  bit   cur_m = 1'b0, garb = 1'b0;
  int   vin [4];
  int   eres [4];
  int   trl;
  logic [3:0] noise = 4'hF;

  always #2 clk = ~clk;

  hybrid_sar_seq u_dut (
    .clk(clk), .rst(rst), .mode12(mode12), .start(start), .cmp_out(cmp),
    .sample_sw(sample_sw), .cap_top(cap_top), .ladder_en(ladder_en),
    .ladder_tap(ladder_tap), .cmp_en_n(cmp_en_n), .assist_m(assist_m),
    .assist_z(assist_z), .result(result), .done(done)
  );

  // comparator model: trial level from the driven thermometer and tap
  always_comb begin
    for (int c = 0; c < 4; c++) begin
      if (cur_m) trl = $countones(cap_top[30:0]) * 128;
      else       trl = $countones(cap_top[c*8 +: 7]) * 128;
      if (ladder_en) trl = trl + int'(ladder_tap) + 1;
      if (cmp_en_n[c]) cmp[c] = garb ? noise[c] : 1'b1;
      else             cmp[c] = (vin[c] >= trl);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] therm(input bit m, input int c, input int n);
    logic [31:0] r = '0;
    for (int i = 0; i < 31; i++) if (m && i < n) r[i] = 1'b1;
    for (int k = 0; k < 7; k++) if (!m && k < n) r[c*8+k] = 1'b1;
    return r;
  endfunction

  always @(negedge clk) begin
    noise <= 4'($urandom);
    cyc   <= cyc + 1;
    if (!rst && !finished) begin
      #1;
      // R6: assist path is off during the clock-low half
      chk(assist_m == 1'b0 && assist_z == 4'b0, "R6 low-half", {assist_m, assist_z}, 0);
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000 && !finished) begin
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic run_conv(input bit m, input int a0, input int a1, input int a2, input int a3,
                          input bit g, input bit poke);
    int nm, ns, nl, smp;
    vin[0] = a0; vin[1] = a1; vin[2] = a2; vin[3] = a3;
    cur_m = m; garb = g;
    nm = m ? 5 : 3; ns = nm + 9; nl = m ? 1 : 4; smp = m ? 3 : 2;
    start = 1'b1; mode12 = m;
    @(posedge clk); #1;
    start = 1'b0;
    for (int s = 0; s < smp; s++) begin
      chk(sample_sw == 1'b1 && cap_top == 0 && cmp_en_n == 4'hF, "R1 sampling",
          {sample_sw, cap_top, cmp_en_n}, {1'b1, 32'h0, 4'hF});
      @(posedge clk); #1;
    end
    chk(sample_sw == 1'b0, "R1 window end", sample_sw, 0);
    for (int c = 0; c < nl; c++) begin
      for (int s = 0; s < ns; s++) begin
        int msb, lsb, ecnt, etap, tr, pos;
        bit elad;
        logic [4:0] eas;
        msb = vin[c] >> 7; lsb = vin[c] & 127;
        ecnt = msb; elad = 0; etap = 0; eas = 0;
        if (s < nm) begin
          pos = nm - 1 - s;
          ecnt = ((msb >> (pos + 1)) << (pos + 1)) | (1 << pos);
        end else if (s > nm && s <= nm + 7) begin
          pos = 6 - (s - nm - 1);
          tr = ((lsb >> (pos + 1)) << (pos + 1)) | (1 << pos);
          elad = 1; etap = tr - 1;
          if (s - nm - 1 < 2) eas = {1'b1, 4'(1 << (tr >> 5))};
        end
        if (poke) begin
          start  = (c == (m ? 0 : 1) && s == 2);
          mode12 = (c == (m ? 0 : 1) && s == 2) ? !m : m;
        end
        chk(cap_top == therm(m, c, ecnt), s < nm ? "R3 thermometer trial" : "R4 held count",
            cap_top, therm(m, c, ecnt));
        chk(ladder_en == elad && ladder_tap == 7'(etap), "R5 ladder tap",
            {ladder_en, ladder_tap}, {elad, 7'(etap)});
        chk(cmp_en_n == (m ? 4'hE : ~(4'b1 << c)), "R2 lane enable", cmp_en_n,
            m ? 4'hE : ~(4'b1 << c));
        chk({assist_m, assist_z} == eas, "R6 assist", {assist_m, assist_z}, eas);
        chk(done == 1'b0 && sample_sw == 1'b0, "R8 no early done", {done, sample_sw}, 0);
        @(posedge clk); #1;
        start = 1'b0; mode12 = m;
      end
    end
    if (m) eres[0] = a0;
    else for (int c = 0; c < 4; c++) eres[c] = vin[c];
    chk(done == 1'b1, "R8 done", done, 1);
    // R7 and R10: codes match the inputs even with noise on disabled lanes
    chk(result == {12'(eres[3]), 12'(eres[2]), 12'(eres[1]), 12'(eres[0])}, g ? "R10 result" : "R7 result",
        result, {12'(eres[3]), 12'(eres[2]), 12'(eres[1]), 12'(eres[0])});
    @(posedge clk); #1;
    chk(done == 1'b0, "R8 single pulse", done, 0);
    // R9: a start during the pass leaves no pending sample window
    chk(sample_sw == 1'b0 && cmp_en_n == 4'hF, "R9 no restart", {sample_sw, cmp_en_n}, 5'h0F);
    garb = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) begin vin[i] = 0; eres[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    chk(sample_sw == 0 && cap_top == 0 && ladder_en == 0 && ladder_tap == 0 &&
        assist_m == 0 && assist_z == 0 && done == 0 && result == 0 && cmp_en_n == 4'hF,
        "R11 reset", {sample_sw, ladder_en, done, cmp_en_n}, 7'h0F);
    rst = 1'b0;
    @(posedge clk); #1;
    run_conv(1'b0, 0, 1023, 512, 511, 1'b0, 1'b0);
    run_conv(1'b0, 127, 128, 896, 895, 1'b0, 1'b1);
    run_conv(1'b1, 0, 0, 0, 0, 1'b0, 1'b0);
    run_conv(1'b1, 4095, 0, 0, 0, 1'b0, 1'b1);
    run_conv(1'b1, 2048, 0, 0, 0, 1'b1, 1'b0);
    for (int r = 0; r < 8; r++)
      run_conv(1'b0, int'($urandom % 1024), int'($urandom % 1024), int'($urandom % 1024),
               int'($urandom % 1024), r[0], r[1]);
    for (int r = 0; r < 8; r++)
      run_conv(1'b1, int'($urandom % 4096), 0, 0, 0, r[0], r[1]);
    finish_run();
  end
endmodule